// File: doc/BRIEF.md
# Programmable Periodic Interrupt Divider

This block derives a periodic event from a slow time base that arrives as a one-cycle enable strobe, nominally at 32768 Hz, in the system clock domain. A free-running counter advances on every strobe from reset onward, whether or not the block is enabled. A 4-bit rate code selects a power-of-two period. Events fall only on counter values that are whole multiples of that period. Each event can raise a periodic-flag set strobe, an interrupt-request set strobe and a one-cycle square-wave pulse.

Two enables gate the outputs. The interrupt enable allows the interrupt-request strobe. The square-wave enable allows the pulse output. While either enable is set and the rate code is nonzero, the divider runs. When the rate code or either enable changes, the pending target is discarded. The block then re-arms to the next aligned boundary above the current count, and no part of the earlier period is carried over.

Top module: `periodic_irq_divider`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all three outputs are low. The tick counter restarts from zero.
- R2: A rate code of 0 produces no event, whatever the enables are.
- R3: The divider runs only when the rate code is nonzero and at least one of `pie_en_i` or `sqw_en_i` is set. With both enables clear, no output ever pulses.
- R4: For rate codes 3 to 15, the period is 2^(code-1) ticks. For example, code 3 gives 4 ticks and code 15 gives 16384 ticks.
- R5: Rate codes 1 and 2 alias to codes 8 and 9, which gives periods of 128 and 256 ticks.
- R6: Events occur only on the tick that moves the free-running count to a multiple of the period. The count is taken modulo 2^CNT_W and runs from reset, so the event phase does not depend on when the block was enabled.
- R7: Every event pulses `pflag_o` for one cycle. `irq_o` pulses with it only when `pie_en_i` is set, and `irq_o` never pulses without `pflag_o`.
- R8: When `sqw_en_i` is set, every event produces a single one-cycle pulse on `sqw_o`, not a toggling level. When `sqw_en_i` is clear, `sqw_o` stays low.
- R9: In the cycle where the rate code or an enable differs from its value in the previous cycle, no event fires. The next event falls on the first multiple of the new period above the count.
- R10: The output pulses appear in the cycle right after the clock edge that samples the qualifying tick.
- R11: A cycle without a tick strobe neither advances the count nor produces an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe from the 32768 Hz time base |
| rate_code_i | input | 4 | Period select; 0 disables the divider |
| pie_en_i | input | 1 | Periodic interrupt enable |
| sqw_en_i | input | 1 | Square-wave pulse enable |
| pflag_o | output | 1 | One-cycle strobe that sets the periodic flag |
| irq_o | output | 1 | One-cycle strobe that sets the interrupt request |
| sqw_o | output | 1 | One-cycle square-wave pulse |

## Verification
Each output pulse is registered once, so it is due exactly one cycle after the edge that samples the qualifying tick and the current configuration. A configuration change is only seen at that same edge. The bench drives its inputs on the falling edge. On each rising edge, its behavioural model reads the same inputs and advances its own count; it decides whether that edge is an event from the count modulo the period and from the previous configuration. On the next falling edge, the model's registered expectation is compared with all three outputs, so every check lands in the cycle where the design must have produced its result.

// File: rtl/pid_pkg.sv
package pid_pkg;
    localparam int RATE_W = 4;

    typedef struct packed {
        logic [RATE_W-1:0] rate;
        logic              pie;
        logic              sqw;
    } pid_cfg_t;
endpackage

// File: rtl/pid_rate_decode.sv
module pid_rate_decode
    import pid_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [RATE_W-1:0] code_i,
    input  logic              pie_i,
    input  logic              sqw_i,
    output logic [CNT_W-1:0]  period_o,
    output logic [CNT_W-1:0]  mask_o,
    output logic              run_o
);
    localparam int NCODE     = 1 << RATE_W;
    localparam int ALIAS_OFS = 7;

    logic [CNT_W-1:0] period_tbl [NCODE];

    for (genvar k = 0; k < NCODE; k++) begin : g_code
        localparam int EFF = (k == 1 || k == 2) ? k + ALIAS_OFS : k;
        if (k == 0) begin : g_off
            assign period_tbl[k] = '0;
        end else begin : g_on
            assign period_tbl[k] = CNT_W'(1) << (EFF - 1);
        end
    end

    always_comb begin
        period_o = period_tbl[code_i];
        mask_o   = period_o - CNT_W'(1);
        run_o    = (code_i != '0) && (pie_i || sqw_i);
    end
endmodule

// File: rtl/pid_tick_counter.sv
module pid_tick_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    output logic [CNT_W-1:0] cnt_d
);
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (tick_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R11
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));

    // R6
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_q == $past(cnt_q) + CNT_W'(1));
endmodule

// File: rtl/pid_arm.sv
module pid_arm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic             chg_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] mask_i,
    output logic             fire_o
);
    logic [CNT_W-1:0] tgt_d, tgt_q;

    always_comb begin
        tgt_d  = tgt_q;
        fire_o = tick_i && run_i && !chg_i && (cnt_next_i == tgt_q);
        if (chg_i || !run_i) begin
            tgt_d = (cnt_next_i & ~mask_i) + period_i;
        end else if (fire_o) begin
            tgt_d = tgt_q + period_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else begin
            tgt_q <= tgt_d;
        end
    end

    // R6
    fire_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> (cnt_next_i & mask_i) == '0);
endmodule

// File: rtl/periodic_irq_divider.sv
module periodic_irq_divider
    import pid_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_code_i,
    input  logic              pie_en_i,
    input  logic              sqw_en_i,
    output logic              pflag_o,
    output logic              irq_o,
    output logic              sqw_o
);
    typedef struct packed {
        pid_cfg_t cfg;
        logic     pflag;
        logic     irq;
        logic     sqw;
    } top_state_t;

    top_state_t       st_d, st_q;
    pid_cfg_t         cur_cfg;
    logic             chg;
    logic             run;
    logic             fire;
    logic [CNT_W-1:0] cnt_next;
    logic [CNT_W-1:0] period;
    logic [CNT_W-1:0] mask;

    pid_rate_decode #(.CNT_W(CNT_W)) u_decode (
        .code_i   (rate_code_i),
        .pie_i    (pie_en_i),
        .sqw_i    (sqw_en_i),
        .period_o (period),
        .mask_o   (mask),
        .run_o    (run)
    );

    pid_tick_counter #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .cnt_d  (cnt_next)
    );

    pid_arm #(.CNT_W(CNT_W)) u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .run_i      (run),
        .chg_i      (chg),
        .cnt_next_i (cnt_next),
        .period_i   (period),
        .mask_i     (mask),
        .fire_o     (fire)
    );

    always_comb begin
        cur_cfg.rate = rate_code_i;
        cur_cfg.pie  = pie_en_i;
        cur_cfg.sqw  = sqw_en_i;
        chg          = (cur_cfg != st_q.cfg);
        st_d         = st_q;
        st_d.cfg     = cur_cfg;
        st_d.pflag   = fire;
        st_d.irq     = fire && pie_en_i;
        st_d.sqw     = fire && sqw_en_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pflag_o = st_q.pflag;
    assign irq_o   = st_q.irq;
    assign sqw_o   = st_q.sqw;

    // R7
    irq_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pflag_o);

    // R2
    code_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pflag_o |-> $past(rate_code_i) != '0);

    // R8
    sqw_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_o |=> !sqw_o);

    // R8
    sqw_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sqw_o |-> $past(sqw_en_i));

    // R9
    rearm_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code_i != $past(rate_code_i)) |=> !pflag_o);
endmodule

// File: tb/tb_periodic_irq_divider.sv
module tb_periodic_irq_divider;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] rate_code_i = 4'd0;
    logic       pie_en_i = 1'b0;
    logic       sqw_en_i = 1'b0;
    logic       pflag_o, irq_o, sqw_o;

    int    n_checks = 0;
    int    n_fail = 0;
    string req_tag = "R1";
    int    tick_div = 1;
    int    cyc = 0;
    bit    done = 1'b0;

    int    m_cnt = 0;
    int    m_prev_cfg = 0;
    bit    exp_pflag = 0, exp_irq = 0, exp_sqw = 0;

    always #5 clk = ~clk;

    periodic_irq_divider dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .rate_code_i (rate_code_i),
        .pie_en_i    (pie_en_i),
        .sqw_en_i    (sqw_en_i),
        .pflag_o     (pflag_o),
        .irq_o       (irq_o),
        .sqw_o       (sqw_o)
    );

    function automatic int period_of(int code);
        if (code == 0) return 0;
        if (code == 1) return 128;
        if (code == 2) return 256;
        return 1 << (code - 1);
    endfunction

    // behavioural reference
    always @(posedge clk) begin
        int cfg;
        int per;
        bit evt;
        cfg = rate_code_i * 4 + pie_en_i * 2 + sqw_en_i;
        if (!rst_n) begin
            m_cnt = 0;
            m_prev_cfg = 0;
            exp_pflag = 0; exp_irq = 0; exp_sqw = 0;
        end else begin
            if (tick_i) m_cnt = (m_cnt + 1) % 65536;
            per = period_of(rate_code_i);
            evt = tick_i && per != 0 && (pie_en_i || sqw_en_i) &&
                  cfg == m_prev_cfg && (m_cnt % per) == 0;
            exp_pflag = evt;
            exp_irq   = evt && pie_en_i;
            exp_sqw   = evt && sqw_en_i;
            m_prev_cfg = cfg;
        end
    end

    task automatic check(string tag, string what, bit act, bit exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // compare on every falling edge, then drive the next inputs
    always @(negedge clk) begin
        if (rst_n) begin
            check(req_tag, "pflag_o", pflag_o, exp_pflag);
            check(req_tag, "irq_o",   irq_o,   exp_irq);
            check(req_tag, "sqw_o",   sqw_o,   exp_sqw);
        end
    end

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            tick_i = (tick_div != 0) && (cyc % tick_div == 0);
        end
    endtask

    task automatic set_cfg(int code, bit pie, bit sqw);
        @(negedge clk);
        cyc++;
        tick_i      = (tick_div != 0) && (cyc % tick_div == 0);
        rate_code_i = code[3:0];
        pie_en_i    = pie;
        sqw_en_i    = sqw;
    endtask

    initial begin
        rate_code_i = 4'd3;
        pie_en_i = 1'b1;
        sqw_en_i = 1'b1;
        tick_i = 1'b1;
        repeat (3) @(negedge clk);
        // R1: outputs low while reset is held
        check("R1", "pflag_o in reset", pflag_o, 1'b0);
        check("R1", "irq_o in reset",   irq_o,   1'b0);
        check("R1", "sqw_o in reset",   sqw_o,   1'b0);
        rst_n = 1'b1;
        req_tag = "R1";
        run_cycles(1);

        req_tag = "R2";  set_cfg(0, 1, 1);  run_cycles(100);
        req_tag = "R3";  set_cfg(3, 0, 0);  run_cycles(100);
        req_tag = "R4";  set_cfg(3, 1, 0);  run_cycles(80);
        req_tag = "R10"; set_cfg(4, 1, 1);  run_cycles(60);
        req_tag = "R8";  tick_div = 2; set_cfg(6, 0, 1); run_cycles(200);
        req_tag = "R7";  set_cfg(5, 1, 0);  run_cycles(150);
        req_tag = "R5";  tick_div = 1; set_cfg(1, 1, 0); run_cycles(600);
        req_tag = "R5";  set_cfg(2, 0, 1);  run_cycles(800);
        req_tag = "R6";  set_cfg(0, 0, 0);  run_cycles(37);
        set_cfg(5, 1, 1); run_cycles(130);
        req_tag = "R9";
        for (int k = 0; k < 12; k++) begin
            set_cfg(3 + (k % 3), k % 2, 1);
            run_cycles(5 + k * 3);
        end
        set_cfg(4, 1, 1); set_cfg(4, 1, 0); set_cfg(4, 1, 1); run_cycles(40);
        req_tag = "R11"; tick_div = 0; set_cfg(3, 1, 1); run_cycles(100);
        tick_div = 3; run_cycles(120);
        req_tag = "R4";  tick_div = 1; set_cfg(15, 1, 1); run_cycles(16500);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule